// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor fetch from an external serial NOR flash as if the flash were plain memory. A single 32-bit setup word describes the whole read transaction. It gives the read command byte, how many address bytes follow it, how many dummy clocks come next and how many data lanes carry the reply. For each read request the engine selects one flash device and sends the command and the address on one lane. It then runs the dummy clocks and collects one to four data bytes on one, two or four lanes. It holds the requester until the bytes are ready.

The serial pins are shared with a separate register-driven command engine. A port-switch input decides which side owns the pins. While the command side owns them, its clock, selects and outputs go straight to the pins. Read requests are then answered at once with zero data, and no serial activity takes place. A setup word of all zeros disables the engine in the same way.

Top module: `sflash_map_reader`

## Requirements
- R1: After a synchronous active-low reset the pins belong to the command side: `flash_sck`, `flash_cs_n`, `flash_io_out` and `flash_io_oe` equal the `cmd_*` inputs, and `rd_ready` is low.
- R2: `port_switch` hands over the pins only while no transaction runs. At 1 the engine drives them and idles with all selects high and the clock low. At 0 the `cmd_*` inputs are mirrored, and an accepted request completes with `rd_ready` in the next cycle, `rd_data` zero and no select asserted.
- R3: While the engine owns the port, a setup word equal to zero makes an accepted request complete in the next cycle with zero data and no serial clock or select activity.
- R4: In the cycle after acceptance, `flash_cs_n[rd_cs]` goes low and stays the only active select. Each serial clock lasts two system cycles, low then high. The count of serial clocks is 8 + 8·(address bytes) + 8·(dummy bytes) + (dummy bits) + 8·(bytes)/(lanes). The edge after the last high half raises the select and drives `rd_ready` high.
- R5: The read command in setup bits 7:0 is sent first, most significant bit first, on `flash_io_out[0]` with `flash_io_oe[0]` = 1.
- R6: Setup bits 9:8 give 0 to 3 address bytes. The low bytes of `rd_addr` follow the command on lane 0, most significant bit first. A count of 0 sends no address.
- R7: Setup bits 11:10 (dummy bytes, 8 clocks each) plus bits 28:24 (extra dummy clocks) set the dummy phase. All output enables are 0 in the dummy and data phases.
- R8: Setup bits 13:12 set the data lanes. 0 means single, sampled on `flash_io_in[1]`. 1 means dual on `[1:0]`, with bit 1 the earlier bit. 3 means quad on `[3:0]`, with bit 3 the earliest bit. The code 2 behaves as single. Input is sampled on the rising serial clock edge.
- R9: `rd_data` returns `rd_bytes_m1`+1 bytes in its low bytes, with the first byte received most significant and all unused upper bytes zero.
- R10: Setup bits 23:16 (write command) have no effect on the read timing, pins or data.
- R11: `rd_ready` is a one-cycle pulse. No request is accepted in that cycle, so a requester that drops `rd_req` on seeing it starts nothing new.
- R12: The setup word, address, length and select are captured at acceptance. Changes to them while a transaction runs do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_switch | input | 1 | 1: engine owns the serial pins; 0: command side owns them |
| setup_word | input | 32 | Read transaction description |
| rd_req | input | 1 | Read request, held until `rd_ready` |
| rd_addr | input | 24 | Flash byte address |
| rd_bytes_m1 | input | 2 | Bytes to read minus one |
| rd_cs | input | 2 | Flash select index |
| rd_ready | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Returned bytes, first byte most significant |
| cmd_sck | input | 1 | Command-side serial clock |
| cmd_cs_n | input | 4 | Command-side selects |
| cmd_io_out | input | 4 | Command-side lane outputs |
| cmd_io_oe | input | 4 | Command-side lane enables |
| flash_sck | output | 1 | Serial clock pin |
| flash_cs_n | output | 4 | Active-low select pins |
| flash_io_out | output | 4 | Lane output values |
| flash_io_oe | output | 4 | Lane output enables |
| flash_io_in | input | 4 | Lane input values |

## Verification
The bench uses the default build: four selects and up to four bytes per read. With these values every select index is exercised, and the upper-byte zeroing can be seen on one- to three-byte reads. The 7-bit phase counter covers the longest dummy phase of 55 clocks, and a quad read with extra dummy bits reaches a data phase only eight clocks long. A behavioural flash model answers on the lanes and records what it receives, and a per-cycle model predicts the select, clock and ready pins.

// File: rtl/sfr_pkg.sv
// Shared types for the serial flash read engine.
// Assumes a 32-bit setup word whose fields are decoded by the sequencer.
package sfr_pkg;

    // Setup word view; field positions are decoded by hardware.
    typedef struct packed {
        logic [2:0] spare_hi;
        logic [4:0] dmy_bits;
        logic [7:0] wr_op;
        logic [1:0] spare_lo;
        logic [1:0] lane_sel;
        logic [1:0] dmy_bytes;
        logic [1:0] adr_bytes;
        logic [7:0] rd_op;
    } setup_t;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_OPC  = 3'd1,
        PH_ADR  = 3'd2,
        PH_DMY  = 3'd3,
        PH_DAT  = 3'd4
    } phase_e;

    // Lane count for a lane-select code; the reserved code falls back to one lane.
    function automatic logic [2:0] lanes_of(input logic [1:0] sel);
        case (sel)
            2'd1:    return 3'd2;
            2'd3:    return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/sfr_seq.sv
// Phase sequencer: steps command, address, dummy and data phases,
// two system cycles per serial clock (low half then high half).
// Assumes the configuration inputs are held stable while not idle.
module sfr_seq
    import sfr_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int BW        = 2,
    parameter int CNT_W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       adr_bytes,
    input  logic [1:0]       dmy_bytes,
    input  logic [4:0]       dmy_bits,
    input  logic [1:0]       lane_sel,
    input  logic [BW-1:0]    nbytes_m1,
    output phase_e           ph,
    output logic [CNT_W-1:0] bidx,
    output logic             sck,
    output logic             sample,
    output logic             done
);
    logic [CNT_W-1:0] len_adr, len_dmy, len_dat, dat_bits, cur_len;
    phase_e           nxt;
    logic             sck_q, done_q;

    // Phase lengths in serial clocks, derived from the captured setup.
    always_comb begin
        dat_bits = CNT_W'((32'(nbytes_m1) + 32'd1) * 32'd8);
        len_adr  = CNT_W'(adr_bytes) << 3;
        len_dmy  = (CNT_W'(dmy_bytes) << 3) + CNT_W'(dmy_bits);
        case (lanes_of(lane_sel))
            3'd4:    len_dat = dat_bits >> 2;
            3'd2:    len_dat = dat_bits >> 1;
            default: len_dat = dat_bits;
        endcase
    end

    // Length of the running phase and the next non-empty phase.
    always_comb begin
        cur_len = CNT_W'(8);
        nxt     = PH_IDLE;
        case (ph)
            PH_OPC: begin
                cur_len = CNT_W'(8);
                nxt     = (len_adr != '0) ? PH_ADR : ((len_dmy != '0) ? PH_DMY : PH_DAT);
            end
            PH_ADR: begin
                cur_len = len_adr;
                nxt     = (len_dmy != '0) ? PH_DMY : PH_DAT;
            end
            PH_DMY: begin
                cur_len = len_dmy;
                nxt     = PH_DAT;
            end
            PH_DAT: begin
                cur_len = len_dat;
                nxt     = PH_IDLE;
            end
            default: begin
                cur_len = CNT_W'(8);
                nxt     = PH_IDLE;
            end
        endcase
    end

    // Phase, bit index and serial clock state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph     <= PH_IDLE;
            bidx   <= '0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ph == PH_IDLE) begin
                if (start) begin
                    ph    <= PH_OPC;
                    bidx  <= '0;
                    sck_q <= 1'b0;
                end
            end else if (!sck_q) begin
                sck_q <= 1'b1;
            end else begin
                sck_q <= 1'b0;
                if (bidx == cur_len - CNT_W'(1)) begin
                    ph   <= nxt;
                    bidx <= '0;
                    if (nxt == PH_IDLE) done_q <= 1'b1;
                end else begin
                    bidx <= bidx + CNT_W'(1);
                end
            end
        end
    end

    assign sck    = sck_q;
    assign done   = done_q;
    assign sample = (ph == PH_DAT) && !sck_q;

    // R4
    bidx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != PH_IDLE) |-> (bidx < cur_len));

    // R4
    done_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(ph) == PH_DAT));

endmodule

// File: rtl/sfr_tx.sv
// Lane-0 driver for the command and address phases.
// Assumes bidx counts serial clocks from zero within each phase.
module sfr_tx
    import sfr_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  phase_e           ph,
    input  logic [CNT_W-1:0] bidx,
    input  logic [7:0]       rd_op,
    input  logic [1:0]       adr_bytes,
    input  logic [23:0]      addr,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe
);
    logic [23:0] adr_al, adr_sh;
    logic [7:0]  op_sh;

    // Left-align the used address bytes so the first bit sits at the top.
    always_comb begin
        case (adr_bytes)
            2'd1:    adr_al = {addr[7:0], 16'h0000};
            2'd2:    adr_al = {addr[15:0], 8'h00};
            2'd3:    adr_al = addr;
            default: adr_al = 24'h000000;
        endcase
        adr_sh = adr_al << bidx;
        op_sh  = rd_op << bidx;
    end

    // Drive one lane during command and address, release all lanes otherwise.
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        if (ph == PH_OPC) begin
            io_out[0] = op_sh[7];
            io_oe[0]  = 1'b1;
        end else if (ph == PH_ADR) begin
            io_out[0] = adr_sh[23];
            io_oe[0]  = 1'b1;
        end
    end

endmodule

// File: rtl/sfr_rx.sv
// Data capture shift register for 1, 2 or 4 lanes.
// Assumes the highest used lane carries the earliest bit of each group.
module sfr_rx #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sample,
    input  logic [2:0]    lanes,
    input  logic [3:0]    io_in,
    output logic [DW-1:0] data
);
    // Shift lane bits in at each rising serial clock of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (clr) begin
            data <= '0;
        end else if (sample) begin
            case (lanes)
                3'd4:    data <= {data[DW-5:0], io_in[3:0]};
                3'd2:    data <= {data[DW-3:0], io_in[1:0]};
                default: data <= {data[DW-2:0], io_in[1]};
            endcase
        end
    end

endmodule

// File: rtl/sflash_map_reader.sv
// Memory-mapped serial flash read engine top: accepts read requests,
// captures the setup word, runs one flash read per request and shares
// the serial pins with a command-mode engine via a port switch.
// Assumes rd_req is held until rd_ready and dropped on seeing it.
module sflash_map_reader
    import sfr_pkg::*;
#(
    parameter int NUM_CS    = 4,
    parameter int MAX_BYTES = 4,
    localparam int CS_W     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BW       = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int DW       = 8 * MAX_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_switch,
    input  logic [31:0]       setup_word,
    input  logic              rd_req,
    input  logic [23:0]       rd_addr,
    input  logic [BW-1:0]     rd_bytes_m1,
    input  logic [CS_W-1:0]   rd_cs,
    output logic              rd_ready,
    output logic [DW-1:0]     rd_data,
    input  logic              cmd_sck,
    input  logic [NUM_CS-1:0] cmd_cs_n,
    input  logic [3:0]        cmd_io_out,
    input  logic [3:0]        cmd_io_oe,
    output logic              flash_sck,
    output logic [NUM_CS-1:0] flash_cs_n,
    output logic [3:0]        flash_io_out,
    output logic [3:0]        flash_io_oe,
    input  logic [3:0]        flash_io_in
);
    localparam int CNT_W = $clog2(MAX_BYTES * 8 + 64);

    setup_t            sw;
    phase_e            ph;
    logic [CNT_W-1:0]  bidx;
    logic              seq_sck, sample, done, busy;
    logic              owner_q, imm_q, accept, en, start;
    logic [7:0]        op_q;
    logic [1:0]        ab_q, db_q, lane_q;
    logic [4:0]        dbits_q;
    logic [23:0]       addr_q;
    logic [BW-1:0]     nb_q;
    logic [CS_W-1:0]   cs_q;
    logic [3:0]        eng_io_out, eng_io_oe;
    logic [NUM_CS-1:0] eng_cs_n;

    assign sw     = setup_word;
    assign busy   = (ph != PH_IDLE);
    assign accept = rd_req && !rd_ready && !busy;
    assign en     = owner_q && (sw != '0);
    assign start  = accept && en;

    // Port ownership follows the switch only between transactions.
    always_ff @(posedge clk) begin
        if (!rst_n)    owner_q <= 1'b0;
        else if (!busy) owner_q <= port_switch;
    end

    // Capture the transaction description at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0; ab_q <= '0; db_q <= '0; lane_q <= '0; dbits_q <= '0;
            addr_q <= '0; nb_q <= '0; cs_q <= '0;
        end else if (start) begin
            op_q    <= sw.rd_op;
            ab_q    <= sw.adr_bytes;
            db_q    <= sw.dmy_bytes;
            lane_q  <= sw.lane_sel;
            dbits_q <= sw.dmy_bits;
            addr_q  <= rd_addr;
            nb_q    <= rd_bytes_m1;
            cs_q    <= rd_cs;
        end
    end

    // Immediate zero-data completion when the engine is not enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) imm_q <= 1'b0;
        else        imm_q <= accept && !en;
    end

    sfr_seq #(.MAX_BYTES(MAX_BYTES), .BW(BW), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .adr_bytes(ab_q), .dmy_bytes(db_q), .dmy_bits(dbits_q), .lane_sel(lane_q),
        .nbytes_m1(nb_q), .ph(ph), .bidx(bidx), .sck(seq_sck),
        .sample(sample), .done(done)
    );

    sfr_tx #(.CNT_W(CNT_W)) tx_i (
        .ph(ph), .bidx(bidx), .rd_op(op_q), .adr_bytes(ab_q), .addr(addr_q),
        .io_out(eng_io_out), .io_oe(eng_io_oe)
    );

    sfr_rx #(.DW(DW)) rx_i (
        .clk(clk), .rst_n(rst_n), .clr(accept), .sample(sample),
        .lanes(lanes_of(lane_q)), .io_in(flash_io_in), .data(rd_data)
    );

    // One select per device, active only for the captured index while busy.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign eng_cs_n[g] = !(busy && (cs_q == CS_W'(g)));
    end

    // Pin mux between this engine and the command side.
    always_comb begin
        if (owner_q) begin
            flash_sck    = seq_sck;
            flash_cs_n   = eng_cs_n;
            flash_io_out = eng_io_out;
            flash_io_oe  = eng_io_oe;
        end else begin
            flash_sck    = cmd_sck;
            flash_cs_n   = cmd_cs_n;
            flash_io_out = cmd_io_out;
            flash_io_oe  = cmd_io_oe;
        end
    end

    assign rd_ready = done || imm_q;

    // R4
    single_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_q |-> $onehot0(~flash_cs_n));

    // R4
    sck_inside_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q && flash_sck) |-> !(&flash_cs_n));

    // R11
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |=> !rd_ready);

    // R12
    capture_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr_q) && $stable(op_q) && $stable(nb_q) && $stable(cs_q)));

    // R4
    release_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && owner_q) |-> (&flash_cs_n));

endmodule

// File: tb/sflash_map_reader_tb.sv
// Bench: behavioural flash model plus a per-cycle pin model.
module sflash_map_reader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_switch = 1'b0;
    logic [31:0] setup_word = '0;
    logic        rd_req = 1'b0;
    logic [23:0] rd_addr = '0;
    logic [1:0]  rd_bytes_m1 = '0;
    logic [1:0]  rd_cs = '0;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic        cmd_sck = 1'b0;
    logic [3:0]  cmd_cs_n = 4'hF;
    logic [3:0]  cmd_io_out = '0;
    logic [3:0]  cmd_io_oe = '0;
    logic        flash_sck;
    logic [3:0]  flash_cs_n;
    logic [3:0]  flash_io_out;
    logic [3:0]  flash_io_oe;
    logic [3:0]  flash_io_in = 4'h0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    sflash_map_reader dut_i (
        .clk(clk), .rst_n(rst_n), .port_switch(port_switch), .setup_word(setup_word),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_bytes_m1(rd_bytes_m1), .rd_cs(rd_cs),
        .rd_ready(rd_ready), .rd_data(rd_data),
        .cmd_sck(cmd_sck), .cmd_cs_n(cmd_cs_n), .cmd_io_out(cmd_io_out), .cmd_io_oe(cmd_io_oe),
        .flash_sck(flash_sck), .flash_cs_n(flash_cs_n), .flash_io_out(flash_io_out),
        .flash_io_oe(flash_io_oe), .flash_io_in(flash_io_in)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int op, input int ab, input int db,
                                       input int lane, input int wr, input int dbits);
        return {3'b000, 5'(dbits), 8'(wr), 2'b00, 2'(lane), 2'(db), 2'(ab), 8'(op)};
    endfunction

    function automatic int lanes_n(input logic [31:0] s);
        return (s[13:12] == 2'd3) ? 4 : ((s[13:12] == 2'd1) ? 2 : 1);
    endfunction

    function automatic int clocks_of(input logic [31:0] s, input int m1);
        return 8 + 8 * int'(s[9:8]) + 8 * int'(s[11:10]) + int'(s[28:24])
               + ((m1 + 1) * 8) / lanes_n(s);
    endfunction

    function automatic logic [7:0] fbyte(input int a);
        return 8'((a * 7 + 8'h35) & 8'hFF);
    endfunction

    // ---------------- per-cycle pin model ----------------
    bit m_busy = 0, m_rdy = 0, m_owner = 0;
    int m_k = 0, m_N = 0, m_cs = 0;

    // Advance the model on each edge from the same inputs the design sees.
    always @(posedge clk) begin
        bit p_busy, p_rdy, p_owner;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_rdy = 0; m_owner = 0; m_k = 0;
        end else begin
            p_busy = m_busy; p_rdy = m_rdy; p_owner = m_owner;
            m_rdy = 0;
            if (p_busy) begin
                m_k++;
                if (m_k == 2 * m_N) begin m_busy = 0; m_rdy = 1; end
            end else if (rd_req && !p_rdy) begin
                if (p_owner && setup_word != 0) begin
                    m_busy = 1; m_k = 0; m_N = clocks_of(setup_word, int'(rd_bytes_m1)); m_cs = int'(rd_cs);
                end else begin
                    m_rdy = 1;
                end
            end
            if (!p_busy) m_owner = port_switch;
        end
    end

    // Compare pins with the model away from the clock edge.
    always @(negedge clk) begin
        logic [3:0] e_cs;
        logic       e_sck;
        if (rst_n) begin
            if (m_owner) begin
                e_sck = m_busy && (m_k % 2 == 1);
                e_cs  = m_busy ? ~(4'b0001 << m_cs) : 4'hF;
                chk(flash_sck == e_sck && flash_cs_n == e_cs && rd_ready == m_rdy,
                    "R4/R11 pin timing (sck,cs_n,ready)",
                    {flash_sck, flash_cs_n, rd_ready}, {e_sck, e_cs, m_rdy});
            end else begin
                chk(flash_sck == cmd_sck && flash_cs_n == cmd_cs_n && flash_io_out == cmd_io_out
                    && flash_io_oe == cmd_io_oe && rd_ready == m_rdy,
                    "R2 command-side mirror",
                    {flash_sck, flash_cs_n, flash_io_out, flash_io_oe, rd_ready},
                    {cmd_sck, cmd_cs_n, cmd_io_out, cmd_io_oe, m_rdy});
            end
        end
    end

    // ---------------- behavioural flash ----------------
    bit          tx_active = 0;
    logic [31:0] t_cfg;
    int          t_cs = 0, t_ea = 0, t_pre = 0, rises = 0, oe_err = 0;
    logic [63:0] mosi;

    function automatic logic sbit(input int n);
        logic [7:0] b;
        b = fbyte(t_ea + n / 8);
        return b[7 - (n % 8)];
    endfunction

    // Record lane-0 bits and check enables on each rising serial clock.
    always @(posedge flash_sck) begin
        if (tx_active && !flash_cs_n[t_cs]) begin
            if (rises < 8 + 8 * int'(t_cfg[9:8])) begin
                mosi = {mosi[62:0], flash_io_out[0]};
                if (flash_io_oe != 4'b0001) oe_err++;
            end else if (flash_io_oe != 4'b0000) begin
                oe_err++;
            end
            rises++;
        end
    end

    // Present data on the lanes after each falling serial clock.
    always @(negedge flash_sck) begin
        int d, ln;
        if (tx_active && !flash_cs_n[t_cs] && rises >= t_pre) begin
            d  = rises - t_pre;
            ln = lanes_n(t_cfg);
            if (ln == 1)      flash_io_in = {2'b00, sbit(d), 1'b0};
            else if (ln == 2) flash_io_in = {2'b00, sbit(2 * d), sbit(2 * d + 1)};
            else              flash_io_in = {sbit(4 * d), sbit(4 * d + 1), sbit(4 * d + 2), sbit(4 * d + 3)};
        end
    end

    // One read request, optionally disturbing inputs mid-transaction (R12).
    task automatic do_read(input logic [23:0] a, input int m1, input int cs,
                           input bit chg, input string tag);
        int          w, ab;
        bit          en;
        logic [31:0] e_data;
        logic [63:0] e_mosi;
        t_cfg = setup_word;
        ab    = int'(t_cfg[9:8]);
        t_cs  = cs;
        t_ea  = int'(a) & ((1 << (8 * ab)) - 1);
        t_pre = 8 + 8 * ab + 8 * int'(t_cfg[11:10]) + int'(t_cfg[28:24]);
        rises = 0; oe_err = 0; mosi = '0;
        en = port_switch && (t_cfg != 0);
        @(negedge clk);
        tx_active   = 1;
        rd_addr     = a;
        rd_bytes_m1 = 2'(m1);
        rd_cs       = 2'(cs);
        rd_req      = 1'b1;
        w = 0;
        do begin
            @(negedge clk);
            w++;
            if (chg && w == 6) begin
                setup_word  = 32'hFFFF_FFFF;
                rd_addr     = ~a;
                rd_bytes_m1 = 2'(~m1);
                rd_cs       = 2'(~cs);
            end
        end while (!rd_ready && w < 2000);
        rd_req = 1'b0;
        e_data = '0;
        if (en) for (int i = 0; i <= m1; i++) e_data = (e_data << 8) | 32'(fbyte(t_ea + i));
        chk(rd_ready == 1'b1, {tag, " ready seen"}, 64'(rd_ready), 64'd1);
        chk(rd_data == e_data, {tag, " data"}, 64'(rd_data), 64'(e_data));
        if (en) begin
            e_mosi = (64'(t_cfg[7:0]) << (8 * ab)) | 64'(t_ea);
            chk(mosi == e_mosi, "R5/R6 command and address bits", mosi, e_mosi);
            chk(oe_err == 0, "R7 lane enables per phase", 64'(oe_err), 64'd0);
        end else begin
            chk(rises == 0, "R2/R3 no serial clocks when disabled", 64'(rises), 64'd0);
        end
        tx_active   = 0;
        flash_io_in = 4'h0;
        setup_word  = t_cfg;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        cmd_sck = 1'b1; cmd_cs_n = 4'b1010; cmd_io_out = 4'h5; cmd_io_oe = 4'h3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state mirrors the command side
        chk(flash_sck == 1'b1 && flash_cs_n == 4'b1010 && flash_io_out == 4'h5 && flash_io_oe == 4'h3
            && rd_ready == 1'b0, "R1 reset state",
            {flash_sck, flash_cs_n, flash_io_out, flash_io_oe, rd_ready}, {1'b1, 4'b1010, 4'h5, 4'h3, 1'b0});

        // R2: command mode answers at once with zero
        setup_word = mk(8'h03, 3, 0, 0, 8'h12, 0);
        do_read(24'h00ABCD, 3, 2, 0, "R2 command-mode read");
        cmd_sck = 1'b0; cmd_cs_n = 4'hF; cmd_io_out = 4'h0; cmd_io_oe = 4'h0;

        // R3: zero setup word disables the engine
        port_switch = 1'b1;
        setup_word  = 32'h0;
        repeat (3) @(negedge clk);
        chk(flash_cs_n == 4'hF && flash_sck == 1'b0, "R2 engine idle pins", {flash_cs_n, flash_sck}, {4'hF, 1'b0});
        do_read(24'h000100, 1, 0, 0, "R3 zero setup read");

        // R4 R5 R6 R9: normal read, 3 address bytes
        setup_word = mk(8'h03, 3, 0, 0, 8'h12, 0);
        do_read(24'h123456, 3, 1, 0, "R9 normal 4-byte read");
        // R9: single byte, upper bytes zero
        do_read(24'h00FF00, 0, 3, 0, "R9 single byte");
        // R7: fast read with one dummy byte
        setup_word = mk(8'h0B, 3, 1, 0, 8'h12, 0);
        do_read(24'hABCDEF, 1, 0, 0, "R7 fast read dummy byte");
        // R8: dual read
        setup_word = mk(8'h6B, 3, 1, 1, 8'h12, 0);
        do_read(24'h0F0F0F, 2, 2, 0, "R8 dual read");
        // R8 R7: quad read with extra dummy bits
        setup_word = mk(8'h6C, 3, 1, 3, 8'h12, 5);
        do_read(24'h765432, 3, 1, 0, "R8 quad read with dummy bits");
        // R8: reserved lane code behaves as single
        setup_word = mk(8'h03, 3, 0, 2, 8'h12, 0);
        do_read(24'h000777, 1, 0, 0, "R8 reserved lane code");
        // R6: no address bytes, then two address bytes
        setup_word = mk(8'h9F, 0, 0, 0, 8'h12, 0);
        do_read(24'hFFFFFF, 2, 0, 0, "R6 zero address bytes");
        setup_word = mk(8'h03, 2, 0, 1, 8'h12, 3);
        do_read(24'h5A1234, 3, 3, 0, "R6 two address bytes");
        // R10: write command field ignored
        setup_word = mk(8'h0B, 3, 1, 0, 8'hFF, 0);
        do_read(24'hABCDEF, 1, 0, 0, "R10 write command ignored");
        // R12: inputs disturbed mid-transaction
        setup_word = mk(8'h6C, 3, 1, 3, 8'h12, 0);
        do_read(24'h024680, 3, 2, 1, "R12 capture at acceptance");
        // R11: back-to-back requests with drop on ready
        setup_word = mk(8'h03, 1, 0, 0, 8'h12, 0);
        do_read(24'h000042, 0, 1, 0, "R11 back-to-back first");
        do_read(24'h000043, 0, 1, 0, "R11 back-to-back second");

        // R2: hand the port back
        port_switch = 1'b0;
        cmd_cs_n = 4'b0111; cmd_io_out = 4'hA; cmd_io_oe = 4'hC;
        repeat (3) @(negedge clk);
        chk(flash_cs_n == 4'b0111 && flash_io_out == 4'hA && flash_io_oe == 4'hC,
            "R2 port returned", {flash_cs_n, flash_io_out, flash_io_oe}, {4'b0111, 4'hA, 4'hC});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule